// File: doc/BRIEF.md
# Single-Command DMA Copy Engine

This block carries out one programmed copy for a DMA channel. Software (or a list walker above it) presents a read address, a write address, a byte count written as count minus one, an access width for each side, an address-increment enable for each side, a burst length and a pacing enable, then pulses `start`. The engine moves the bytes through a simple request/grant/acknowledge memory port, one access in flight at a time. Each access reads a chunk and then writes the same chunk. A chunk is never wider than either side's width, the bytes left in the current burst, or the bytes left in the command.

When pacing is on, every burst waits for the device request line before its first read. This lets a slow peripheral throttle memory-to-device or device-to-memory traffic. A live remaining-size output reports the bytes still to move, minus one, so progress can be polled. A `cancel` pulse stops the command at the next access boundary. A one-cycle `done` pulse marks normal completion.

Top module: `dce_cmd_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, `busy` is low, `mem_req` is low and `remain_m1` reads all ones (0xFFFFFF for a 24-bit size).
- R2: A `start` pulse while idle latches the command; `cfg_size_m1` holds the byte count minus one, exactly that count plus one bytes are written, and while busy `remain_m1` reports the bytes not yet written minus one.
- R3: Width codes are log2 of bytes (0=1, 1=2, 2=4, 3=8); codes above 3 act as 8 bytes; each access length (`mem_len`, in bytes, 1..8) is the smallest of read width, write width, bytes left in the burst and bytes left in the command.
- R4: With `cfg_rd_inc` set the read address advances by each access length, otherwise it stays fixed; `cfg_wr_inc` does the same independently for the write address.
- R5: A burst is `cfg_burst_m1`+1 bytes; a burst never runs past the command's remaining bytes, so the last access is shortened to exactly the bytes that remain.
- R6: With `cfg_pace_en` set, each burst starts only after `dev_req` is sampled high; while it stays low no memory request is made.
- R7: One access is outstanding at a time; a request holds its address, direction and length until granted; data is little-endian with byte 0 in `mem_rdata[7:0]` / `mem_wdata[7:0]`.
- R8: `done` is high for exactly one cycle, the cycle after the last write is acknowledged, and `busy` is low in that cycle.
- R9: After `cancel`, no new access is granted beyond one already being requested; the engine then goes idle with `remain_m1` all ones and no `done` pulse.
- R10: A `start` pulse while busy is ignored and does not alter or queue a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch the command (accepted only when idle) |
| cancel | input | 1 | Abort the running command at the next access boundary |
| cfg_rd_addr | input | ADDR_W | Read start address |
| cfg_wr_addr | input | ADDR_W | Write start address |
| cfg_size_m1 | input | SIZE_W | Byte count minus one |
| cfg_rd_code | input | 3 | Read width, log2 bytes |
| cfg_wr_code | input | 3 | Write width, log2 bytes |
| cfg_rd_inc | input | 1 | Advance read address per access |
| cfg_wr_inc | input | 1 | Advance write address per access |
| cfg_burst_m1 | input | BURST_W | Burst length in bytes minus one |
| cfg_pace_en | input | 1 | Wait for `dev_req` before each burst |
| dev_req | input | 1 | Device request line |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access byte address |
| mem_len | output | LEN_W | Access length in bytes |
| mem_wdata | output | DATA_W | Write data, little-endian |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | DATA_W | Read data, little-endian |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| remain_m1 | output | SIZE_W | Bytes still to write minus one; all ones when none |

## Verification
The bench targets the length arithmetic: a 7-byte copy at 8-byte width and a 10-byte copy with 4-byte bursts. A design that failed to clip the last access would write past the end of the destination and spoil a guard byte. Fixed-address reads and writes are run separately, so an engine that tied the two increments together would move the wrong address. A paced copy is held off with the request line low and then let through one burst at a time; an engine that ignored the line, or sampled it only once per command, would show reads too early or too many writes per pulse. Cancel in the middle of a copy and a second start during a copy are checked at the ports. A design that kept issuing accesses, raised `done`, left a stale remaining count or queued the second command would show it in the grant count, the done count or `remain_m1`.

// File: rtl/dce_pkg.sv
// Package: shared types for the single-command DMA copy engine.
// Assumes: at most 8 states; configuration fields are latched together at start.
package dce_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURST,
        ST_DREQ,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT
    } dce_state_e;

    typedef struct packed {
        logic [2:0] rd_code;
        logic [2:0] wr_code;
        logic       rd_inc;
        logic       wr_inc;
        logic       pace_en;
    } dce_cfg_t;

endpackage

// File: rtl/dce_step_calc.sv
// Module: dce_step_calc
// Computes the byte length of the next access as the smallest of the read
// width, write width, bytes left in the burst and bytes left in the command.
// Assumes: BURST_W+1 <= SIZE_W+1; width codes above MAX_CODE are clamped.
module dce_step_calc #(
    parameter int SIZE_W   = 24,
    parameter int BURST_W  = 8,
    parameter int LEN_W    = 4,
    parameter int MAX_CODE = 3
) (
    input  logic [2:0]       rd_code,
    input  logic [2:0]       wr_code,
    input  logic [SIZE_W:0]  rem,
    input  logic [BURST_W:0] burst_left,
    output logic [LEN_W-1:0] step
);
    localparam int CW = SIZE_W + 1;

    logic [2:0]    code;
    logic [CW-1:0] cand;

    // Pick the narrower side, clamp it to the bus, then clip by burst and command.
    always_comb begin
        code = (rd_code < wr_code) ? rd_code : wr_code;
        if (code > 3'(MAX_CODE)) code = 3'(MAX_CODE);
        cand = CW'(1) << code;
        if (rem < cand) cand = rem;
        if (CW'(burst_left) < cand) cand = CW'(burst_left);
        step = cand[LEN_W-1:0];
    end

endmodule

// File: rtl/dce_addr_ctr.sv
// Module: dce_addr_ctr
// One side's address register: loads the start address and, when enabled,
// steps forward by the completed access length.
// Assumes: step is stable for the whole access that it advances over.
module dce_addr_ctr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              adv,
    input  logic              inc,
    input  logic [LEN_W-1:0]  step,
    output logic [ADDR_W-1:0] addr
);

    // Hold, load or advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (adv && inc) begin
            addr <= addr + ADDR_W'(step);
        end
    end

endmodule

// File: rtl/dce_seq.sv
// Module: dce_seq
// Control sequencer: bursts, pacing, the read-then-write access pair,
// remaining byte count, cancel and the done pulse.
// Assumes: one access outstanding; mem_ack arrives only for a granted access.
module dce_seq
    import dce_pkg::*;
#(
    parameter int SIZE_W  = 24,
    parameter int BURST_W = 8,
    parameter int LEN_W   = 4,
    parameter int DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cancel,
    input  logic [SIZE_W-1:0]  size_m1,
    input  logic [BURST_W-1:0] burst_m1,
    input  logic               pace_en,
    input  logic               dev_req,
    input  logic [LEN_W-1:0]   step,
    input  logic               mem_gnt,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               load,
    output logic               rd_adv,
    output logic               wr_adv,
    output logic [SIZE_W:0]    rem,
    output logic [BURST_W:0]   burst_left,
    output logic               busy,
    output logic               done
);
    localparam int RW = SIZE_W + 1;
    localparam int BW = BURST_W + 1;

    dce_state_e        state;
    logic              abort_q;
    logic              abort;
    logic [DATA_W-1:0] data_q;
    logic [RW-1:0]     rem_n;
    logic [BW-1:0]     bl_n;
    logic [BW-1:0]     blen;

    // Decode the handshake outputs and the next-count values.
    always_comb begin
        abort   = abort_q | cancel;
        busy    = (state != ST_IDLE);
        mem_req = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        mem_we  = (state == ST_WR_REQ);
        load    = start && (state == ST_IDLE);
        rd_adv  = (state == ST_RD_WAIT) && mem_ack;
        wr_adv  = (state == ST_WR_WAIT) && mem_ack;
        rem_n   = rem - RW'(step);
        bl_n    = burst_left - BW'(step);
        blen    = BW'(burst_m1) + BW'(1);
    end

    assign mem_wdata = data_q;

    // Main state register with counts, captured read data and abort latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            rem        <= '0;
            burst_left <= '0;
            abort_q    <= 1'b0;
            done       <= 1'b0;
            data_q     <= '0;
        end else begin
            done <= 1'b0;
            if (cancel && state != ST_IDLE) abort_q <= 1'b1;
            case (state)
                ST_IDLE: begin
                    abort_q <= 1'b0;
                    if (start) begin
                        rem   <= RW'(size_m1) + RW'(1);
                        state <= ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (abort) begin
                        rem   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        burst_left <= (rem < RW'(blen)) ? BW'(rem) : blen;
                        state      <= pace_en ? ST_DREQ : ST_RD_REQ;
                    end
                end
                ST_DREQ: begin
                    if (abort) begin
                        rem   <= '0;
                        state <= ST_IDLE;
                    end else if (dev_req) begin
                        state <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (mem_gnt) state <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        if (abort) begin
                            rem   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_WR_REQ;
                        end
                    end
                end
                ST_WR_REQ: begin
                    if (mem_gnt) state <= ST_WR_WAIT;
                end
                ST_WR_WAIT: begin
                    if (mem_ack) begin
                        if (abort) begin
                            rem   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            rem        <= rem_n;
                            burst_left <= bl_n;
                            if (rem_n == '0) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else if (bl_n == '0) begin
                                state <= ST_BURST;
                            end else begin
                                state <= ST_RD_REQ;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dce_cmd_engine.sv
// Module: dce_cmd_engine (top)
// Executes one copy command over a request/grant/ack memory port, with
// per-side widths and increments, bursts, device pacing and cancel.
// Assumes: DATA_W is a power-of-two number of bytes, at least 8 bits.
module dce_cmd_engine
    import dce_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int SIZE_W  = 24,
    parameter int BURST_W = 8,
    localparam int MAX_CODE = $clog2(DATA_W / 8),
    localparam int LEN_W    = MAX_CODE + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cancel,
    input  logic [ADDR_W-1:0]  cfg_rd_addr,
    input  logic [ADDR_W-1:0]  cfg_wr_addr,
    input  logic [SIZE_W-1:0]  cfg_size_m1,
    input  logic [2:0]         cfg_rd_code,
    input  logic [2:0]         cfg_wr_code,
    input  logic               cfg_rd_inc,
    input  logic               cfg_wr_inc,
    input  logic [BURST_W-1:0] cfg_burst_m1,
    input  logic               cfg_pace_en,
    input  logic               dev_req,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LEN_W-1:0]   mem_len,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_gnt,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [SIZE_W-1:0]  remain_m1
);
    localparam int NSIDE = 2;   // index 0 = read side, 1 = write side

    dce_cfg_t           cfg_q;
    logic [BURST_W-1:0] burst_q;
    logic               load;
    logic               rd_adv;
    logic               wr_adv;
    logic [SIZE_W:0]    rem;
    logic [BURST_W:0]   burst_left;
    logic [LEN_W-1:0]   step;
    logic [ADDR_W-1:0]  side_base [NSIDE];
    logic [ADDR_W-1:0]  side_addr [NSIDE];
    logic               side_adv  [NSIDE];
    logic               side_inc  [NSIDE];

    // Latch the per-command configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            burst_q <= '0;
        end else if (load) begin
            cfg_q   <= '{rd_code: cfg_rd_code, wr_code: cfg_wr_code,
                         rd_inc: cfg_rd_inc, wr_inc: cfg_wr_inc,
                         pace_en: cfg_pace_en};
            burst_q <= cfg_burst_m1;
        end
    end

    dce_seq #(
        .SIZE_W (SIZE_W),
        .BURST_W(BURST_W),
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cancel    (cancel),
        .size_m1   (cfg_size_m1),
        .burst_m1  (burst_q),
        .pace_en   (cfg_q.pace_en),
        .dev_req   (dev_req),
        .step      (step),
        .mem_gnt   (mem_gnt),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .load      (load),
        .rd_adv    (rd_adv),
        .wr_adv    (wr_adv),
        .rem       (rem),
        .burst_left(burst_left),
        .busy      (busy),
        .done      (done)
    );

    dce_step_calc #(
        .SIZE_W  (SIZE_W),
        .BURST_W (BURST_W),
        .LEN_W   (LEN_W),
        .MAX_CODE(MAX_CODE)
    ) u_step (
        .rd_code   (cfg_q.rd_code),
        .wr_code   (cfg_q.wr_code),
        .rem       (rem),
        .burst_left(burst_left),
        .step      (step)
    );

    assign side_base[0] = cfg_rd_addr;
    assign side_base[1] = cfg_wr_addr;
    assign side_adv[0]  = rd_adv;
    assign side_adv[1]  = wr_adv;
    assign side_inc[0]  = cfg_q.rd_inc;
    assign side_inc[1]  = cfg_q.wr_inc;

    // One address counter per side.
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dce_addr_ctr #(
            .ADDR_W(ADDR_W),
            .LEN_W (LEN_W)
        ) u_ctr (
            .clk  (clk),
            .rst_n(rst_n),
            .load (load),
            .base (side_base[s]),
            .adv  (side_adv[s]),
            .inc  (side_inc[s]),
            .step (step),
            .addr (side_addr[s])
        );
    end

    assign mem_addr  = mem_we ? side_addr[1] : side_addr[0];
    assign mem_len   = step;
    assign remain_m1 = rem[SIZE_W-1:0] - SIZE_W'(1);

endmodule

// File: rtl/dce_checker.sv
// Module: dce_checker
// Port-level properties of dce_cmd_engine, attached with bind.
// Assumes: LEN_W and widths match the engine defaults passed in.
module dce_checker #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 24,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_len,
    input logic              busy,
    input logic              done,
    input logic [SIZE_W-1:0] remain_m1
);
    localparam int MAXLEN = 1 << (LEN_W - 1);

    a_r1_idle_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (remain_m1 == {SIZE_W{1'b1}}));

    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0) && (32'(mem_len) <= MAXLEN));

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_we)
                                  && $stable(mem_addr) && $stable(mem_len));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_remain_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (remain_m1 <= $past(remain_m1)));

endmodule

bind dce_cmd_engine dce_checker #(
    .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .mem_len  (mem_len),
    .busy     (busy),
    .done     (done),
    .remain_m1(remain_m1)
);

// File: tb/dce_cmd_engine_tb.sv
`timescale 1ns/100ps
module dce_cmd_engine_tb;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 64;
    localparam int SIZE_W  = 24;
    localparam int BURST_W = 8;
    localparam int LEN_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, cancel = 1'b0;
    logic [ADDR_W-1:0]  cfg_rd_addr = '0, cfg_wr_addr = '0;
    logic [SIZE_W-1:0]  cfg_size_m1 = '0;
    logic [2:0]         cfg_rd_code = '0, cfg_wr_code = '0;
    logic               cfg_rd_inc = 1'b1, cfg_wr_inc = 1'b1;
    logic [BURST_W-1:0] cfg_burst_m1 = '1;
    logic               cfg_pace_en = 1'b0;
    logic               dev_req = 1'b0;
    logic               mem_req, mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    logic [LEN_W-1:0]   mem_len;
    logic [DATA_W-1:0]  mem_wdata;
    logic               mem_gnt;
    logic               mem_ack = 1'b0;
    logic [DATA_W-1:0]  mem_rdata = '0;
    logic               busy, done;
    logic [SIZE_W-1:0]  remain_m1;

    always #2.5 clk = ~clk;

    dce_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
        .cfg_rd_addr(cfg_rd_addr), .cfg_wr_addr(cfg_wr_addr),
        .cfg_size_m1(cfg_size_m1), .cfg_rd_code(cfg_rd_code),
        .cfg_wr_code(cfg_wr_code), .cfg_rd_inc(cfg_rd_inc),
        .cfg_wr_inc(cfg_wr_inc), .cfg_burst_m1(cfg_burst_m1),
        .cfg_pace_en(cfg_pace_en), .dev_req(dev_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .remain_m1(remain_m1)
    );

    // ---------------- memory model and monitors ----------------
    logic [7:0] mem [256];
    logic       stall_en = 1'b0;
    logic [7:0] cyc = '0;
    logic       ack_we = 1'b0;
    int n_rd = 0, n_wr = 0, n_gnt = 0, last_len = 0, max_len = 0;
    int rd_first = -1, wr_first = -1;
    bit rd_moved = 1'b0, wr_moved = 1'b0;
    int done_cnt = 0, done_bad = 0;
    bit last_wr_ack = 1'b0, last_done = 1'b0;

    assign mem_gnt = !(stall_en && cyc[0]);

    always @(posedge clk) begin
        cyc     <= cyc + 8'd1;
        mem_ack <= 1'b0;
        if (mem_req && mem_gnt) begin
            mem_ack <= 1'b1;
            ack_we  <= mem_we;
            n_gnt   = n_gnt + 1;
            if (mem_we) begin
                for (int i = 0; i < int'(mem_len); i++)
                    mem[8'(mem_addr + ADDR_W'(i))] <= mem_wdata[8*i +: 8];
                n_wr     = n_wr + 1;
                last_len = int'(mem_len);
                if (int'(mem_len) > max_len) max_len = int'(mem_len);
                if (wr_first < 0) wr_first = int'(mem_addr);
                else if (int'(mem_addr) != wr_first) wr_moved = 1'b1;
            end else begin
                for (int i = 0; i < 8; i++)
                    mem_rdata[8*i +: 8] <= (i < int'(mem_len)) ?
                        mem[8'(mem_addr + ADDR_W'(i))] : 8'h00;
                n_rd = n_rd + 1;
                if (rd_first < 0) rd_first = int'(mem_addr);
                else if (int'(mem_addr) != rd_first) rd_moved = 1'b1;
            end
        end
    end

    // Done pulse monitor: counts pulses, checks width and position after a write ack.
    always @(posedge clk) begin
        if (rst_n) begin
            if (done) begin
                done_cnt = done_cnt + 1;
                if (!last_wr_ack || last_done) done_bad = done_bad + 1;
            end
        end
        last_done   = done;
        last_wr_ack = mem_ack && ack_we;
    end

    // ---------------- checking helpers ----------------
    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic logic [7:0] src_pat(int a);
        return 8'(a * 37 + 11);
    endfunction

    task automatic fill_mem();
        for (int a = 0; a < 256; a++)
            mem[a] = (a < 128) ? src_pat(a) : 8'hEE;
    endtask

    task automatic clear_stats();
        n_rd = 0; n_wr = 0; n_gnt = 0; last_len = 0; max_len = 0;
        rd_first = -1; wr_first = -1; rd_moved = 1'b0; wr_moved = 1'b0;
    endtask

    task automatic setup(input int ra, input int wa, input int size,
                         input int rc, input int wc, input bit ri, input bit wi,
                         input int burst, input bit pace);
        cfg_rd_addr  = ADDR_W'(ra);
        cfg_wr_addr  = ADDR_W'(wa);
        cfg_size_m1  = SIZE_W'(size - 1);
        cfg_rd_code  = 3'(rc);
        cfg_wr_code  = 3'(wc);
        cfg_rd_inc   = ri;
        cfg_wr_inc   = wi;
        cfg_burst_m1 = BURST_W'(burst - 1);
        cfg_pace_en  = pace;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int d0 = done_cnt;
        int t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
        check(done_cnt == d0 + 1, req, "done pulse count", done_cnt - d0, 1);
    endtask

    task automatic check_copy(input string req, input int sa, input int da, input int n);
        int errs = 0;
        for (int i = 0; i < n; i++)
            if (mem[da + i] !== src_pat(sa + i)) errs++;
        check(errs == 0, req, "copied bytes wrong", errs, 0);
        check(mem[da + n] === 8'hEE, req, "guard byte after copy", mem[da + n], 8'hEE);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        check(remain_m1 == 24'hFFFFFF, "R1", "remain after reset", remain_m1, 24'hFFFFFF);
    endtask

    task automatic t_memcpy();
        fill_mem(); clear_stats(); stall_en = 1'b1;
        setup(8'h00, 8'h80, 20, 3, 3, 1, 1, 16, 0);
        pulse_start();
        check(remain_m1 == 24'd19, "R2", "remain right after start", remain_m1, 19);
        wait_done("R8");
        stall_en = 1'b0;
        check_copy("R2", 8'h00, 8'h80, 20);
        check(n_wr == 3, "R5", "writes for 20B, 16B bursts", n_wr, 3);
        check(last_len == 4, "R5", "tail access length", last_len, 4);
        check(done_bad == 0, "R8", "done pulse shape/position", done_bad, 0);
        check(remain_m1 == 24'hFFFFFF, "R1", "remain after done", remain_m1, 24'hFFFFFF);
    endtask

    task automatic t_mixed();
        fill_mem(); clear_stats();
        setup(8'h10, 8'h90, 6, 2, 1, 1, 1, 256, 0);
        pulse_start(); wait_done("R3");
        check_copy("R3", 8'h10, 8'h90, 6);
        check(n_wr == 3 && max_len == 2, "R3", "write count with 4B/2B widths", n_wr, 3);
    endtask

    task automatic t_short();
        fill_mem(); clear_stats();
        setup(8'h03, 8'h85, 7, 3, 3, 1, 1, 256, 0);
        pulse_start(); wait_done("R5");
        check_copy("R5", 8'h03, 8'h85, 7);
        check(n_wr == 1 && last_len == 7, "R5", "7B copy single length", last_len, 7);
        fill_mem(); clear_stats();
        setup(8'h20, 8'hA0, 10, 3, 3, 1, 1, 4, 0);
        pulse_start(); wait_done("R5");
        check_copy("R5", 8'h20, 8'hA0, 10);
        check(n_wr == 3 && last_len == 2, "R5", "10B in 4B bursts tail", last_len, 2);
        fill_mem(); clear_stats();
        setup(8'h30, 8'hB0, 1, 3, 3, 1, 1, 256, 0);
        pulse_start(); wait_done("R2");
        check_copy("R2", 8'h30, 8'hB0, 1);
        check(n_wr == 1, "R2", "size field zero moves one byte", n_wr, 1);
    endtask

    task automatic t_bad_code();
        fill_mem(); clear_stats();
        setup(8'h08, 8'h88, 16, 7, 5, 1, 1, 256, 0);
        pulse_start(); wait_done("R3");
        check_copy("R3", 8'h08, 8'h88, 16);
        check(n_wr == 2 && max_len == 8, "R3", "codes above 3 act as 8B", n_wr, 2);
    endtask

    task automatic t_fixed();
        int errs = 0;
        fill_mem(); clear_stats();
        setup(8'h40, 8'h90, 12, 2, 3, 0, 1, 256, 0);
        pulse_start(); wait_done("R4");
        check(!rd_moved && wr_moved, "R4", "fixed read, moving write", rd_moved, 0);
        for (int i = 0; i < 12; i++)
            if (mem[8'h90 + i] !== src_pat(8'h40 + (i % 4))) errs++;
        check(errs == 0, "R4", "repeated source word", errs, 0);
        fill_mem(); clear_stats();
        setup(8'h10, 8'hC0, 8, 3, 2, 1, 0, 256, 0);
        pulse_start(); wait_done("R4");
        check(!wr_moved && rd_moved, "R4", "fixed write, moving read", wr_moved, 0);
        check(mem[8'hC0] === src_pat(8'h14), "R4", "last word at fixed target",
              mem[8'hC0], src_pat(8'h14));
    endtask

    task automatic t_pacing();
        fill_mem(); clear_stats(); dev_req = 1'b0;
        setup(8'h00, 8'h80, 12, 2, 2, 1, 1, 4, 1);
        pulse_start();
        repeat (20) @(negedge clk);
        check(n_rd == 0, "R6", "reads with dev_req low", n_rd, 0);
        dev_req = 1'b1;
        @(negedge clk) dev_req = 1'b0;
        repeat (20) @(negedge clk);
        check(n_wr == 1, "R6", "writes after one request pulse", n_wr, 1);
        check(remain_m1 == 24'd7, "R2", "remain after one paced burst", remain_m1, 7);
        dev_req = 1'b1;
        wait_done("R6");
        dev_req = 1'b0;
        check(n_wr == 3, "R6", "total paced writes", n_wr, 3);
        check_copy("R6", 8'h00, 8'h80, 12);
    endtask

    task automatic t_cancel();
        int g0, d0;
        fill_mem(); clear_stats();
        setup(8'h00, 8'h80, 100, 0, 0, 1, 1, 256, 0);
        d0 = done_cnt;
        pulse_start();
        repeat (30) @(negedge clk);
        cancel = 1'b1; g0 = n_gnt;
        @(negedge clk) cancel = 1'b0;
        repeat (10) @(negedge clk);
        check(busy == 1'b0, "R9", "busy after cancel", busy, 0);
        check(n_gnt - g0 <= 1, "R9", "grants after cancel", n_gnt - g0, 1);
        check(remain_m1 == 24'hFFFFFF, "R9", "remain after cancel", remain_m1, 24'hFFFFFF);
        check(n_wr < 100, "R9", "copy stopped early", n_wr, 99);
        g0 = n_gnt;
        repeat (20) @(negedge clk);
        check(n_gnt == g0 && done_cnt == d0, "R9", "no activity/done after cancel",
              done_cnt - d0, 0);
    endtask

    task automatic t_busy_start();
        fill_mem(); clear_stats();
        setup(8'h00, 8'h80, 16, 0, 0, 1, 1, 256, 0);
        pulse_start();
        repeat (5) @(negedge clk);
        setup(8'h50, 8'hD0, 3, 0, 0, 1, 1, 256, 0);
        pulse_start();
        wait_done("R10");
        check(n_wr == 16, "R10", "writes of first command only", n_wr, 16);
        check_copy("R10", 8'h00, 8'h80, 16);
        repeat (10) @(negedge clk);
        check(busy == 1'b0 && n_wr == 16, "R10", "second start not queued", n_wr, 16);
    endtask

    // ---------------- run ----------------
    initial begin
        fill_mem();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_memcpy();
        t_mixed();
        t_short();
        t_bad_code();
        t_fixed();
        t_pacing();
        t_cancel();
        t_busy_start();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

endmodule